// File: doc/BRIEF.md
# Mirror-Subcarrier I/Q Imbalance Compensator

This block removes the image interference that gain, phase and filter mismatch between the I and Q paths leave on a 64-bin OFDM symbol after the FFT. A correction ratio D(k) is known only at twelve bins, six on each side of DC. The block expands these ratios to all 56 used bins. The gaps between measured bins are filled by linear interpolation with power-of-two weights, so the logic needs only shifts and adds. A 3-tap [1 2 1]/4 window in frequency then smooths the full set of ratios. Each used bin k is corrected as Z(k) = Y(k) − D(k)·conj(Y(−k)), which costs one complex multiply and one subtract per bin. The gain and phase scaling that remains after correction is left for the channel equaliser downstream.

The whole symbol is held in a buffer, so the mirror bin of any output is already present. The design is a two-state machine. In FILL it accepts the 64 bins in FFT bin order; bin n stands for subcarrier k = n for n < 32 and k = n − 64 otherwise. On the transition FILL→DRAIN, taken when bin 63 is stored, the block begins to emit. DRAIN emits one corrected bin per cycle. On the transition DRAIN→FILL, taken after bin 63 has been emitted, the block returns to collecting.

Top module: `iqc_mirror_comp`

## Requirements
- R1: While reset is held and directly after it, out_valid and out_sos are 0.
- R2: In FILL, a sample with in_valid=1 and in_sos=1 is stored as bin 0. Each following sample with in_valid=1 and in_sos=0 is stored as the next bin. Cycles with in_valid=0 are skipped. A sample with in_sos=0 that arrives before any start marker is discarded. A new in_sos starts the symbol again from bin 0.
- R3: The measured ratio anchors sit at anc_re/anc_im bits [14j+13:14j]. For j = 0..5 the anchor is at k = +4(j+1); for j = 6..11 it is at k = −4(j−5). For 4 < |k| < 24 on one side, raw D = A_i + floor(f·(A_{i+1} − A_i)/4), with i = |k|/4 − 1 and f = |k| mod 4. For |k| ≤ 4 the raw ratio equals the anchor at |k| = 4, and for |k| ≥ 24 it equals the anchor at |k| = 24.
- R4: The ratio used at |k| is floor((r(|k|−1) + 2r(|k|) + r(|k|+1) + 2)/4), taken per side and per component. At |k| = 1 and |k| = 28 the missing neighbour is replaced by the end value itself.
- R5: Ratios and samples are signed two's complement, and ratios carry 13 fraction bits. For a used bin, P = D·conj(Y(−k)). Each component of P is rounded as floor((x + 4096)/8192), and the output is Y(k) − P.
- R6: An output component outside −8192..8191 is clipped to the nearest limit.
- R7: Bin 0 (DC) and bins with |k| > 28 are emitted unchanged.
- R8: Output starts only after all 64 bins have been stored. It runs 64 consecutive cycles in bin order, and out_sos is set only on bin 0.
- R9: Input samples that arrive during DRAIN are ignored, whatever their in_sos value. After returning to FILL, the block again waits for a start marker.
- R10: Anchors are captured on the start-marker sample. Changes to anchors later in the same symbol do not affect its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sos | input | 1 | Marks bin 0 of an input symbol |
| in_re | input | 14 | Input real part |
| in_im | input | 14 | Input imaginary part |
| anc_re | input | 168 | Twelve anchor ratios, real parts |
| anc_im | input | 168 | Twelve anchor ratios, imaginary parts |
| out_valid | output | 1 | Output sample strobe |
| out_sos | output | 1 | Marks bin 0 of an output symbol |
| out_re | output | 14 | Corrected real part |
| out_im | output | 14 | Corrected imaginary part |

## Verification
Anchors that alternate between the full-scale extremes stress the interpolation. A block that truncated toward zero instead of flooring, or that indexed the wrong anchor pair, would miss by one or more codes on bins whose fraction is 1 or 3. Large mirrored values with strong ratios drive the subtraction past both limits, where a missing clip would wrap the sign. Stray samples before the start marker, gaps, a restart in mid-symbol, a start marker sent during output and anchors changed after the start marker each check the capture and ordering rules. A block that got any of these wrong would emit a shifted symbol, emit one too early, or correct with the wrong ratios.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

    // Two phases of the compensator: collect a symbol, then emit it.
    typedef enum logic [0:0] {
        S_FILL  = 1'b0,
        S_DRAIN = 1'b1
    } iqc_state_e;

endpackage

// File: rtl/iqc_ratio_expand.sv
// Expands sparse per-side anchors to every used bin with shift-only
// linear interpolation; ends replicate the nearest anchor.
module iqc_ratio_expand #(
    parameter int RW      = 14,
    parameter int HALF    = 28,
    parameter int NAS     = 6,
    parameter int SP_LOG2 = 2
) (
    input  logic [2*NAS*RW-1:0]  anc,
    output logic [2*HALF*RW-1:0] raw
);
    localparam int SP   = 1 << SP_LOG2;
    localparam int LAST = SP * NAS;
    localparam int EW   = RW + 1 + SP_LOG2;

    for (genvar s = 0; s < 2; s++) begin : g_side
        for (genvar m = 1; m <= HALF; m++) begin : g_bin
            if (m <= SP) begin : g_low
                assign raw[(s*HALF+m-1)*RW +: RW] = anc[(s*NAS)*RW +: RW];
            end else if (m >= LAST) begin : g_high
                assign raw[(s*HALF+m-1)*RW +: RW] = anc[(s*NAS+NAS-1)*RW +: RW];
            end else begin : g_mid
                localparam int I = m / SP - 1;
                localparam int F = m % SP;
                logic signed [RW-1:0] a0, a1, r;
                logic signed [EW-1:0] diff, acc, step;

                assign a0   = anc[(s*NAS+I)*RW +: RW];
                assign a1   = anc[(s*NAS+I+1)*RW +: RW];
                assign diff = EW'(a1) - EW'(a0);

                always_comb begin
                    acc = '0;
                    for (int b = 0; b < SP_LOG2; b++) begin
                        if (((F >> b) & 1) != 0) acc = acc + (diff <<< b);
                    end
                end

                assign step = acc >>> SP_LOG2;
                assign r    = RW'(EW'(a0) + step);
                assign raw[(s*HALF+m-1)*RW +: RW] = r;

                // R3: an interpolated ratio lies between its two anchors
                always_comb begin
                    if (!$isunknown({a0, a1, r})) begin
                        a_r3_interp_between: assert ((r >= a0 || r >= a1) && (r <= a0 || r <= a1))
                            else $error("interpolated ratio outside its anchors");
                    end
                end
            end
        end
    end

endmodule

// File: rtl/iqc_ratio_smooth.sv
// 3-tap [1 2 1]/4 window across bins of one side, ends replicated.
module iqc_ratio_smooth #(
    parameter int RW   = 14,
    parameter int HALF = 28
) (
    input  logic [2*HALF*RW-1:0] raw,
    output logic [2*HALF*RW-1:0] smo
);
    localparam int SW = RW + 3;

    for (genvar s = 0; s < 2; s++) begin : g_side
        for (genvar m = 1; m <= HALF; m++) begin : g_bin
            localparam int LO = (m == 1)    ? m : m - 1;
            localparam int HI = (m == HALF) ? m : m + 1;
            logic signed [RW-1:0] xl, xc, xh, y;
            logic signed [SW-1:0] sum;

            assign xl  = raw[(s*HALF+LO-1)*RW +: RW];
            assign xc  = raw[(s*HALF+m-1)*RW +: RW];
            assign xh  = raw[(s*HALF+HI-1)*RW +: RW];
            assign sum = SW'(xl) + (SW'(xc) <<< 1) + SW'(xh) + SW'(2);
            assign y   = RW'(sum >>> 2);
            assign smo[(s*HALF+m-1)*RW +: RW] = y;

            // R4: the smoothed value stays within the span of its window
            always_comb begin
                if (!$isunknown({xl, xc, xh, y})) begin
                    a_r4_smooth_between: assert ((y >= xl || y >= xc || y >= xh) &&
                                                 (y <= xl || y <= xc || y <= xh))
                        else $error("smoothed ratio outside its window");
                end
            end
        end
    end

endmodule

// File: rtl/iqc_corrector.sv
// One complex multiply-subtract against the conjugated mirror bin.
module iqc_corrector #(
    parameter int DW   = 14,
    parameter int RW   = 14,
    parameter int FRAC = 13
) (
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    input  logic signed [DW-1:0] m_re,
    input  logic signed [DW-1:0] m_im,
    input  logic signed [RW-1:0] d_re,
    input  logic signed [RW-1:0] d_im,
    input  logic                 used,
    output logic signed [DW-1:0] z_re,
    output logic signed [DW-1:0] z_im
);
    localparam int PW = DW + RW + 1;
    localparam int ZW = PW + 1;
    localparam logic signed [PW-1:0] RND  = PW'(1) <<< (FRAC - 1);
    localparam logic signed [ZW-1:0] ZMAX = ZW'((1 << (DW - 1)) - 1);
    localparam logic signed [ZW-1:0] ZMIN = ~ZMAX;

    logic signed [PW-1:0] acc_re, acc_im, p_re, p_im;
    logic signed [ZW-1:0] w_re, w_im;

    function automatic logic signed [DW-1:0] clip(input logic signed [ZW-1:0] v);
        if (v > ZMAX) return DW'(ZMAX);
        if (v < ZMIN) return DW'(ZMIN);
        return DW'(v);
    endfunction

    // (a + jb)(c - jd) = (ac + bd) + j(bc - ad)
    assign acc_re = PW'(d_re) * PW'(m_re) + PW'(d_im) * PW'(m_im);
    assign acc_im = PW'(d_im) * PW'(m_re) - PW'(d_re) * PW'(m_im);
    assign p_re   = (acc_re + RND) >>> FRAC;
    assign p_im   = (acc_im + RND) >>> FRAC;
    assign w_re   = ZW'(y_re) - ZW'(p_re);
    assign w_im   = ZW'(y_im) - ZW'(p_im);
    assign z_re   = used ? clip(w_re) : y_re;
    assign z_im   = used ? clip(w_im) : y_im;

endmodule

// File: rtl/iqc_mirror_comp.sv
module iqc_mirror_comp
    import iqc_pkg::*;
#(
    parameter int DW      = 14,
    parameter int RW      = 14,
    parameter int FRAC    = 13,
    parameter int NFFT    = 64,
    parameter int HALF    = 28,
    parameter int NAS     = 6,
    parameter int SP_LOG2 = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sos,
    input  logic signed [DW-1:0]    in_re,
    input  logic signed [DW-1:0]    in_im,
    input  logic [2*NAS*RW-1:0]     anc_re,
    input  logic [2*NAS*RW-1:0]     anc_im,
    output logic                    out_valid,
    output logic                    out_sos,
    output logic signed [DW-1:0]    out_re,
    output logic signed [DW-1:0]    out_im
);
    localparam int AW = $clog2(NFFT);
    localparam logic [AW-1:0] LAST_BIN = AW'(NFFT - 1);

    iqc_state_e state_q, state_d;

    logic [AW-1:0]           wcnt_q, rcnt_q, wr_idx, mir_idx, mag;
    logic                    collecting_q, accept, side_neg, used;
    logic [2*NAS*RW-1:0]     anc_re_q, anc_im_q;
    logic [2*HALF*RW-1:0]    raw_re, raw_im, smo_re, smo_im;
    logic signed [DW-1:0]    sym_re_q [NFFT];
    logic signed [DW-1:0]    sym_im_q [NFFT];
    logic signed [RW-1:0]    d_re, d_im;
    logic signed [DW-1:0]    z_re, z_im;
    int                      ridx;

    // ---------------- ratio expansion ----------------
    iqc_ratio_expand #(.RW(RW), .HALF(HALF), .NAS(NAS), .SP_LOG2(SP_LOG2))
        u_exp_re (.anc(anc_re_q), .raw(raw_re));
    iqc_ratio_expand #(.RW(RW), .HALF(HALF), .NAS(NAS), .SP_LOG2(SP_LOG2))
        u_exp_im (.anc(anc_im_q), .raw(raw_im));
    iqc_ratio_smooth #(.RW(RW), .HALF(HALF))
        u_smo_re (.raw(raw_re), .smo(smo_re));
    iqc_ratio_smooth #(.RW(RW), .HALF(HALF))
        u_smo_im (.raw(raw_im), .smo(smo_im));

    // ---------------- bin addressing ----------------
    assign accept  = (state_q == S_FILL) && in_valid && (in_sos || collecting_q);
    assign wr_idx  = in_sos ? '0 : wcnt_q;
    assign mir_idx = '0 - rcnt_q;

    always_comb begin
        side_neg = rcnt_q[AW-1];
        mag      = side_neg ? mir_idx : rcnt_q;
        used     = (mag != '0) && (int'(mag) <= HALF);
        ridx     = used ? (int'(side_neg) * HALF + int'(mag) - 1) : 0;
        d_re     = smo_re[ridx*RW +: RW];
        d_im     = smo_im[ridx*RW +: RW];
    end

    iqc_corrector #(.DW(DW), .RW(RW), .FRAC(FRAC)) u_corr (
        .y_re (sym_re_q[rcnt_q]),
        .y_im (sym_im_q[rcnt_q]),
        .m_re (sym_re_q[mir_idx]),
        .m_im (sym_im_q[mir_idx]),
        .d_re (d_re),
        .d_im (d_im),
        .used (used),
        .z_re (z_re),
        .z_im (z_im)
    );

    // ---------------- state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FILL:  if (accept && wr_idx == LAST_BIN) state_d = S_DRAIN;
            S_DRAIN: if (rcnt_q == LAST_BIN)           state_d = S_FILL;
            default: state_d = S_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FILL;
        else        state_q <= state_d;
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q       <= '0;
            rcnt_q       <= '0;
            collecting_q <= 1'b0;
            anc_re_q     <= '0;
            anc_im_q     <= '0;
            out_valid    <= 1'b0;
            out_sos      <= 1'b0;
            out_re       <= '0;
            out_im       <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sos   <= 1'b0;
            unique case (state_q)
                S_FILL: begin
                    if (accept) begin
                        wcnt_q       <= wr_idx + 1'b1;
                        collecting_q <= (wr_idx != LAST_BIN);
                        if (in_sos) begin
                            anc_re_q <= anc_re;
                            anc_im_q <= anc_im;
                        end
                    end
                end
                S_DRAIN: begin
                    out_valid <= 1'b1;
                    out_sos   <= (rcnt_q == '0);
                    out_re    <= z_re;
                    out_im    <= z_im;
                    rcnt_q    <= rcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            sym_re_q[wr_idx] <= in_re;
            sym_im_q[wr_idx] <= in_im;
        end
    end

    // ---------------- assertions ----------------
    // R8: the start marker never appears without a valid sample
    a_r8_sos_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sos |-> out_valid);

    // R8: within a symbol the output strobe is unbroken
    a_r8_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sos) |-> $past(out_valid));

    // R8: output only follows a cycle spent emitting
    a_r8_from_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state_q) == S_DRAIN));

    // R9, R10: captured anchors cannot move while a symbol is emitted
    a_r10_anchor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN) |=> ($stable(anc_re_q) && $stable(anc_im_q)));

endmodule

// File: tb/iqc_mirror_comp_tb_top.sv
module iqc_mirror_comp_tb_top;
    localparam int DW   = 14;
    localparam int RW   = 14;
    localparam int NFFT = 64;
    localparam int HALF = 28;
    localparam int NA   = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n, in_valid, in_sos;
    logic signed [DW-1:0] in_re, in_im;
    logic [NA*RW-1:0]     anc_re, anc_im;
    logic                 out_valid, out_sos;
    logic signed [DW-1:0] out_re, out_im;

    iqc_mirror_comp dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_re(in_re), .in_im(in_im), .anc_re(anc_re), .anc_im(anc_im),
        .out_valid(out_valid), .out_sos(out_sos), .out_re(out_re), .out_im(out_im)
    );

    int anc_v_re [NA];
    int anc_v_im [NA];
    int cap_re   [NA];
    int cap_im   [NA];
    int sym_re   [NFFT];
    int sym_im   [NFFT];

    int    q_re[$];
    int    q_im[$];
    int    q_sos[$];
    string q_tag[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic int rnd(int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    task automatic set_anchors();
        for (int j = 0; j < NA; j++) begin
            anc_re[j*RW +: RW] = RW'(anc_v_re[j]);
            anc_im[j*RW +: RW] = RW'(anc_v_im[j]);
        end
    endtask

    // ---- reference model written from the requirements ----
    function automatic int anc_at(int side, int j, bit im);
        return im ? cap_im[side*6+j] : cap_re[side*6+j];
    endfunction

    function automatic int raw_at(int side, int m, bit im);   // R3
        int i, f;
        if (m <= 4)  return anc_at(side, 0, im);
        if (m >= 24) return anc_at(side, 5, im);
        i = m / 4 - 1;
        f = m % 4;
        return anc_at(side, i, im) + ((f * (anc_at(side, i + 1, im) - anc_at(side, i, im))) >>> 2);
    endfunction

    function automatic int smo_at(int side, int m, bit im);   // R4
        int lo, hi;
        lo = (m == 1)    ? m : m - 1;
        hi = (m == HALF) ? m : m + 1;
        return (raw_at(side, lo, im) + 2 * raw_at(side, m, im) + raw_at(side, hi, im) + 2) >>> 2;
    endfunction

    function automatic int clip(int v);                       // R6
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    task automatic expect_bin(int n, string tag);             // R5, R7
        int side, mag, mir, a, b, c, d, pr, pi, zr, zi;
        side = (n < 32) ? 0 : 1;
        mag  = (n < 32) ? n : NFFT - n;
        mir  = (NFFT - n) % NFFT;
        if (mag < 1 || mag > HALF) begin
            zr = sym_re[n];
            zi = sym_im[n];
        end else begin
            a  = smo_at(side, mag, 0);
            b  = smo_at(side, mag, 1);
            c  = sym_re[mir];
            d  = sym_im[mir];
            pr = (a * c + b * d + 4096) >>> 13;
            pi = (b * c - a * d + 4096) >>> 13;
            zr = clip(sym_re[n] - pr);
            zi = clip(sym_im[n] - pi);
        end
        q_re.push_back(zr);
        q_im.push_back(zi);
        q_sos.push_back(n == 0 ? 1 : 0);
        q_tag.push_back(tag);
    endtask

    task automatic drive(bit v, bit s, int re, int im);
        @(negedge clk);
        in_valid = v;
        in_sos   = s;
        in_re    = DW'(re);
        in_im    = DW'(im);
    endtask

    task automatic send_symbol(string tag, bit gaps, bit chg);
        cap_re = anc_v_re;
        cap_im = anc_v_im;
        for (int n = 0; n < NFFT; n++) expect_bin(n, tag);
        for (int n = 0; n < NFFT; n++) begin
            if (n == NFFT - 1) begin
                checks++;
                if (out_valid !== 1'b0) begin
                    fails++;
                    $display("FAIL R8 output before full symbol: actual=%b expected=0", out_valid);
                end
            end
            drive(1'b1, n == 0, sym_re[n], sym_im[n]);
            if (chg && n == 1) begin       // R10: change after the marker
                for (int j = 0; j < NA; j++) begin
                    anc_v_re[j] = rnd(8000);
                    anc_v_im[j] = rnd(8000);
                end
                set_anchors();
            end
            if (gaps && (n % 5 == 2)) drive(1'b0, 1'b1, 1234, -1234);
        end
        drive(1'b0, 1'b0, 0, 0);
    endtask

    task automatic wait_drained();
        wait (q_re.size() == 0);
        repeat (4) @(negedge clk);
    endtask

    // ---- monitor / scoreboard ----
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (q_re.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R9 unexpected output: actual=%0d/%0d expected=none", out_re, out_im);
            end else begin
                int er, ei, es;
                string tg;
                er = q_re.pop_front();
                ei = q_im.pop_front();
                es = q_sos.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if (int'(out_re) != er || int'(out_im) != ei) begin
                    fails++;
                    $display("FAIL %s data: actual=%0d,%0d expected=%0d,%0d", tg, out_re, out_im, er, ei);
                end
                checks++;
                if (int'(out_sos) != es) begin
                    fails++;
                    $display("FAIL R8 marker: actual=%0d expected=%0d", out_sos, es);
                end
            end
        end
    end

    // ---- watchdog ----
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sos = 1'b0; in_re = '0; in_im = '0;
        anc_re = '0; anc_im = '0;
        repeat (3) @(negedge clk);
        checks++;                                                  // R1
        if (out_valid !== 1'b0 || out_sos !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual=%b%b expected=00", out_valid, out_sos);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sos !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: actual=%b%b expected=00", out_valid, out_sos);
        end

        // zero ratios: identity on every bin
        for (int j = 0; j < NA; j++) begin anc_v_re[j] = 0; anc_v_im[j] = 0; end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(8000); sym_im[n] = rnd(8000); end
        send_symbol("R5", 1'b0, 1'b0);
        wait_drained();

        // moderate random ratios
        for (int j = 0; j < NA; j++) begin anc_v_re[j] = rnd(2000); anc_v_im[j] = rnd(2000); end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(3000); sym_im[n] = rnd(3000); end
        send_symbol("R3 R4 R5", 1'b0, 1'b0);
        wait_drained();

        // alternating full-scale anchors stress interpolation floors
        for (int j = 0; j < NA; j++) begin
            anc_v_re[j] = (j % 2 == 0) ? 8191 : -8191 + j;
            anc_v_im[j] = (j % 2 == 0) ? -8192 + 3 * j : 8187;
        end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(4000); sym_im[n] = rnd(4000); end
        send_symbol("R3 R4", 1'b0, 1'b0);
        wait_drained();

        // full-scale nulls and DC next to strong ratios
        for (int j = 0; j < NA; j++) begin anc_v_re[j] = rnd(6000); anc_v_im[j] = rnd(6000); end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(8191); sym_im[n] = rnd(8191); end
        sym_re[0] = 8191; sym_im[0] = -8192; sym_re[32] = -8192; sym_im[32] = 8191;
        send_symbol("R7", 1'b0, 1'b0);
        wait_drained();

        // saturation in both directions
        for (int j = 0; j < NA; j++) begin anc_v_re[j] = -8000; anc_v_im[j] = 3000; end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin
            sym_re[n] = (n % 2 == 1) ? 8000 : -8000;
            sym_im[n] = (n % 3 == 0) ? 8100 : -8100;
        end
        send_symbol("R6", 1'b0, 1'b0);
        wait_drained();

        // stray samples before a marker, a restart, and gaps
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 77, 77);
        drive(1'b0, 1'b0, 0, 0);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 stray samples produced output: actual=%b expected=0", out_valid);
        end
        for (int i = 0; i < 10; i++) drive(1'b1, i == 0, 999, -999);
        for (int j = 0; j < NA; j++) begin anc_v_re[j] = rnd(3000); anc_v_im[j] = rnd(3000); end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(5000); sym_im[n] = rnd(5000); end
        send_symbol("R2", 1'b1, 1'b0);
        wait_drained();

        // anchors changed after the marker, then junk during output
        for (int j = 0; j < NA; j++) begin anc_v_re[j] = rnd(4000); anc_v_im[j] = rnd(4000); end
        set_anchors();
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(6000); sym_im[n] = rnd(6000); end
        send_symbol("R10", 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) drive(1'b1, (i % 7) == 0, 4321, -4321);
        drive(1'b0, 1'b0, 0, 0);
        wait_drained();
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 55, -55);
        for (int n = 0; n < NFFT; n++) begin sym_re[n] = rnd(6000); sym_im[n] = rnd(6000); end
        send_symbol("R9", 1'b0, 1'b0);
        wait_drained();

        checks++;
        if (q_re.size() != 0) begin
            fails++;
            $display("FAIL R8 missing outputs: actual=%0d pending expected=0", q_re.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule